// File: doc/BRIEF.md
# SPI Master Receive Capture with Selectable Sampling Edge

This block is the receive half of an SPI master. It watches the serial clock and the slave's data line, and it moves both into the system clock domain through a synchronizer chain. It records the data line once at every SCK rise and once at every SCK fall, each into its own register. One configuration bit chooses which of the two recorded values becomes the next received bit. Because the choice is made on data and not on the clock, the block can serve slaves that launch data on either edge, and no slave needs extra hold time.

Each received bit is shifted into a receive shift register, most significant bit first, when a rising SCK edge is detected. A bit counter tracks the bits of a byte. When the last bit lands, the assembled word is copied into a holding register and a receive-full flag rises. The flag stays up until the host pulses its read strobe. The holding register keeps its value for a whole byte time, so the host can read it while the next byte is arriving. A partial byte is thrown away when the slave select drops, when a bus contention error is flagged, or when the block is disabled.

Top module: `spi_rx_capture`

## Requirements
- R1: After reset, `rx_byte` is all zeros and `rx_full` is 0.
- R2: With `rise_sel` = 1, each shifted bit is the MISO value recorded at the SCK rising edge that triggers the shift.
- R3: With `rise_sel` = 0, each shifted bit is the MISO value recorded at the most recent SCK falling edge before the rising edge that triggers the shift.
- R4: Bits are assembled MSB first. After DATA_W accepted rising edges, `rx_byte` holds the received word. The first bit received ends up in bit DATA_W-1.
- R5: `rx_full` goes to 1 in the same cycle that `rx_byte` is loaded. A one-cycle `host_rd` pulse clears it on the next clock.
- R6: If a byte completes while `rx_full` is already 1, `rx_byte` takes the new word and `rx_full` stays 1.
- R7: While `ss_active` is 0, SCK edges are not counted, and a partial byte is discarded. The next byte after reselection is received intact.
- R8: A cycle with `bus_err` = 1 discards any partial byte, in the same way as R7.
- R9: While `en` is 0, the bit count and the partial word are cleared and `rx_full` is forced to 0. `rx_byte` keeps its last value.
- R10: Latency is fixed. Suppose the final SCK rise is first registered at clock edge m. Then `rx_byte` and `rx_full` update at edge m+STAGES+1.
- R11: `rx_byte` changes only in a cycle where a byte completes. A host read does not alter it.
- R12: If a byte completes in the same cycle as a `host_rd` pulse, `rx_full` ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Receive path enable; 0 clears the count, the partial word and `rx_full` |
| ss_active | input | 1 | 1 while the master holds a slave selected |
| bus_err | input | 1 | Contention error; 1 discards the partial byte |
| rise_sel | input | 1 | 1 takes the rising-edge sample, 0 takes the falling-edge sample |
| sck | input | 1 | Serial clock as driven on the bus |
| miso | input | 1 | Serial data from the slave |
| host_rd | input | 1 | One-cycle pulse when the host reads the holding register |
| rx_byte | output | DATA_W | Receive holding register |
| rx_full | output | 1 | 1 while an unread byte sits in `rx_byte` |

## Verification
The hardest case to reach is a host read that lands in exactly the same system clock cycle as the byte-complete event. That event follows the last SCK rise by the synchronizer depth plus two register stages. The bench counts clock edges from the moment it drives the eighth rise and raises `host_rd` on the matching edge. It also drives a falling-sample mode (idle-high clock, first phase) and an edge choice that does not match the slave, so that the delayed falling-edge sample feeds the shift. A per-clock reference model, built from queues of the driven pin history, confirms every cycle.

// File: rtl/spi_rxcap_pkg.sv
package spi_rxcap_pkg;

  // Choice of which SCK edge's MISO sample feeds the shift register.
  typedef enum logic {
    SEL_FALL = 1'b0,
    SEL_RISE = 1'b1
  } edge_sel_e;

  // Bit counter step: wraps to zero after the last bit of a word.
  function automatic int unsigned next_count(input int unsigned cur,
                                             input int unsigned last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction

  // True when the count marks the final bit of a word.
  function automatic logic is_last(input int unsigned cur,
                                   input int unsigned last);
    return cur == last;
  endfunction

endpackage

// File: rtl/rxcap_front.sv
// Synchronizes SCK and MISO together and flags SCK edges as one-cycle pulses.
module rxcap_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic miso_in,
  output logic miso_sync,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int LANES    = 2;
  localparam int SCK_LANE = 1;
  localparam int DAT_LANE = 0;

  logic [STAGES-1:0][LANES-1:0] chain;
  logic                          sck_prev;
  logic                          sck_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= {sck_in, miso_in};
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign sck_sync  = chain[STAGES-1][SCK_LANE];
  assign miso_sync = chain[STAGES-1][DAT_LANE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_sync;
  end

  assign rise_evt = sck_sync & ~sck_prev;
  assign fall_evt = ~sck_sync & sck_prev;
endmodule

// File: rtl/rxcap_sampler.sv
// Two MISO sample registers, one per SCK edge, and the data mux between them.
module rxcap_sampler
  import spi_rxcap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_evt,
  input  logic fall_evt,
  input  logic miso_sync,
  input  logic rise_sel,
  output logic pick
);
  logic      samp_rise;
  logic      samp_fall;
  edge_sel_e sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        samp_rise <= 1'b0;
    else if (rise_evt) samp_rise <= miso_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        samp_fall <= 1'b0;
    else if (fall_evt) samp_fall <= miso_sync;
  end

  assign sel = edge_sel_e'(rise_sel);

  always_comb begin
    unique case (sel)
      SEL_RISE: pick = samp_rise;
      SEL_FALL: pick = samp_fall;
      default:  pick = samp_fall;
    endcase
  end
endmodule

// File: rtl/rxcap_assembler.sv
// Receive shift register with bit counter and byte-complete detection.
module rxcap_assembler
  import spi_rxcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ss_active,
  input  logic              bus_err,
  input  logic              shift_evt,
  input  logic              pick,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [DATA_W-1:0] word_next,
  output logic              done_evt
);
  localparam int LAST = DATA_W - 1;

  logic [DATA_W-1:0] shreg;
  logic              accept;

  // Append one bit at the LSB end so the first bit ends up at the MSB.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] w,
                                                 input logic b);
    return {w[DATA_W-2:0], b};
  endfunction

  assign accept    = en & ss_active & ~bus_err & shift_evt;
  assign word_next = shift_in(shreg, pick);
  assign done_evt  = accept & is_last(int'(bit_cnt), LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!en) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (!ss_active || bus_err) begin
      bit_cnt <= '0;
    end else if (accept) begin
      shreg   <= word_next;
      bit_cnt <= CNT_W'(next_count(int'(bit_cnt), LAST));
    end
  end
endmodule

// File: rtl/rxcap_holding.sv
// Receive holding register and receive-full flag in the system domain.
module rxcap_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              done_evt,
  input  logic [DATA_W-1:0] word_in,
  input  logic              host_rd,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_byte <= '0;
    else if (done_evt) rx_byte <= word_in;
  end

  // A completion in the same cycle as a read leaves the flag set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_full <= 1'b0;
    else if (!en)      rx_full <= 1'b0;
    else if (done_evt) rx_full <= 1'b1;
    else if (host_rd)  rx_full <= 1'b0;
  end
endmodule

// File: rtl/spi_rx_capture.sv
module spi_rx_capture #(
  parameter int DATA_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ss_active,
  input  logic              bus_err,
  input  logic              rise_sel,
  input  logic              sck,
  input  logic              miso,
  input  logic              host_rd,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_full
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  // Named internal events, visible to the bound checker.
  logic              miso_sync;
  logic              rise_evt;
  logic              fall_evt;
  logic              shift_evt;
  logic              pick;
  logic              done_evt;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] word_next;

  rxcap_front #(.STAGES(STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_in   (sck),
    .miso_in  (miso),
    .miso_sync(miso_sync),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  // The shift waits one cycle so the rising-edge sample register is settled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_evt <= 1'b0;
    else        shift_evt <= rise_evt;
  end

  rxcap_sampler u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .miso_sync(miso_sync),
    .rise_sel (rise_sel),
    .pick     (pick)
  );

  rxcap_assembler #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .ss_active(ss_active),
    .bus_err  (bus_err),
    .shift_evt(shift_evt),
    .pick     (pick),
    .bit_cnt  (bit_cnt),
    .word_next(word_next),
    .done_evt (done_evt)
  );

  rxcap_holding #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .done_evt(done_evt),
    .word_in (word_next),
    .host_rd (host_rd),
    .rx_byte (rx_byte),
    .rx_full (rx_full)
  );
endmodule

// File: rtl/spi_rx_capture_chk.sv
module spi_rx_capture_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              ss_active,
  input logic              bus_err,
  input logic              host_rd,
  input logic              done_evt,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] rx_byte,
  input logic              rx_full
);
  a_r5_full_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> rx_full);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && host_rd && !done_evt) |=> !rx_full);

  a_r6_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_full && !host_rd) |=> rx_full);

  a_r12_set_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && host_rd) |=> rx_full);

  a_r7_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ss_active) |=> (bit_cnt == '0));

  a_r8_error_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bus_err) |=> (bit_cnt == '0));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!rx_full && bit_cnt == '0));

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(rx_byte));

  a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bit_cnt) < DATA_W);
endmodule

bind spi_rx_capture spi_rx_capture_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .ss_active(ss_active),
  .bus_err  (bus_err),
  .host_rd  (host_rd),
  .done_evt (done_evt),
  .bit_cnt  (bit_cnt),
  .rx_byte  (rx_byte),
  .rx_full  (rx_full)
);

// File: tb/spi_rx_capture_bench.sv
module spi_rx_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int S          = 2;
  localparam int HIST       = S + 3;

  logic          clk;
  logic          rst_n;
  logic          en;
  logic          ss_active;
  logic          bus_err;
  logic          rise_sel;
  logic          sck;
  logic          miso;
  logic          host_rd;
  logic [DW-1:0] rx_byte;
  logic          rx_full;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  ended  = 0;

  spi_rx_capture #(.DATA_W(DW), .STAGES(S)) u_spi_rx_capture (
    .clk(clk), .rst_n(rst_n), .en(en), .ss_active(ss_active),
    .bus_err(bus_err), .rise_sel(rise_sel), .sck(sck), .miso(miso),
    .host_rd(host_rd), .rx_byte(rx_byte), .rx_full(rx_full)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: queues of driven pin values; a rise or fall is seen
  // S+1 edges after it was driven, the shift one edge after that.
  int sck_h[$];
  int dat_h[$];
  int m_sh, m_cnt, m_hold, m_full, m_rs, m_fs;
  bit model_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      sck_h.delete(); dat_h.delete();
      for (int i = 0; i < HIST - 1; i++) begin sck_h.push_back(0); dat_h.push_back(0); end
      m_sh = 0; m_cnt = 0; m_hold = 0; m_full = 0; m_rs = 0; m_fs = 0;
    end else begin
      int jo, jn, b;
      bit done;
      sck_h.push_back(int'(sck)); dat_h.push_back(int'(miso));
      if (sck_h.size() > HIST) begin void'(sck_h.pop_front()); void'(dat_h.pop_front()); end
      jo = HIST - 2 - S;   // pin index whose rise shifts now
      jn = jo + 1;         // pin index whose edge is sampled now
      done = 0;
      if (!en) begin
        m_cnt = 0; m_sh = 0;
      end else if (!ss_active || bus_err) begin
        m_cnt = 0;
      end else if (sck_h[jo] == 1 && sck_h[jo-1] == 0) begin
        b = rise_sel ? m_rs : m_fs;
        m_sh = ((m_sh * 2) + b) % 256;
        m_cnt = m_cnt + 1;
        if (m_cnt == DW) begin m_hold = m_sh; m_cnt = 0; done = 1; end
      end
      if (!en) m_full = 0;
      else if (done) m_full = 1;
      else if (host_rd) m_full = 0;
      if (sck_h[jn] == 1 && sck_h[jn-1] == 0) m_rs = dat_h[jn];
      if (sck_h[jn] == 0 && sck_h[jn-1] == 1) m_fs = dat_h[jn];
    end
  end

  // R10: per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && model_on && !ended) begin
      chk("R10 rx_byte", 32'(rx_byte), 32'(m_hold));
      chk("R10 rx_full", 32'(rx_full), 32'(m_full));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Idle-low clock, data valid at the rise.
  task automatic send_lo_first(input logic [7:0] b, input int h, input bit rd_last);
    for (int i = 7; i >= 0; i--) begin
      miso = b[i];
      idle(h);
      sck = 1'b1;
      if (i == 0 && rd_last) begin
        idle(S + 1);
        host_rd = 1'b1;
        idle(1);
        host_rd = 1'b0;
      end else begin
        idle(h);
      end
      sck = 1'b0;
    end
  endtask

  // Idle-high clock, data launched at the fall, sampled at the rise.
  task automatic send_hi_second(input logic [7:0] b, input int h);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; miso = b[i];
      idle(h);
      sck = 1'b1;
      idle(h);
    end
  endtask

  // Idle-high clock, data valid before the fall, sampled at the fall.
  task automatic send_hi_first(input logic [7:0] b, input int h);
    for (int i = 7; i >= 0; i--) begin
      miso = b[i];
      idle(h);
      sck = 1'b0;
      idle(h);
      sck = 1'b1;
    end
  endtask

  task automatic pulse_rd();
    host_rd = 1'b1; idle(1); host_rd = 1'b0;
  endtask

  initial begin
    rst_n = 0; en = 0; ss_active = 0; bus_err = 0; rise_sel = 1;
    sck = 0; miso = 0; host_rd = 0;
    idle(4);
    chk("R1 rx_byte", 32'(rx_byte), 0);
    chk("R1 rx_full", 32'(rx_full), 0);
    rst_n = 1; model_on = 1;
    en = 1; idle(2);

    // R2/R4: idle-low, rise sampling
    ss_active = 1; idle(2);
    send_lo_first(8'hA5, 2, 0);
    idle(6); ss_active = 0; idle(2);
    chk("R4 byte A5", 32'(rx_byte), 32'h A5);
    chk("R5 full set", 32'(rx_full), 1);
    pulse_rd(); idle(1);
    chk("R5 full cleared", 32'(rx_full), 0);
    chk("R11 read keeps byte", 32'(rx_byte), 32'h A5);

    // R2: idle-high, rise sampling
    sck = 1; idle(6);
    ss_active = 1; idle(2);
    send_hi_second(8'h3C, 3);
    idle(6); ss_active = 0; idle(2);
    chk("R2 byte 3C", 32'(rx_byte), 32'h3C);

    // R3/R6: falling-edge sample, previous byte unread
    rise_sel = 0;
    ss_active = 1; idle(2);
    send_hi_first(8'hC3, 2);
    idle(6); ss_active = 0; idle(2);
    chk("R3 byte C3", 32'(rx_byte), 32'h C3);
    chk("R6 full stays", 32'(rx_full), 1);

    // R3: mismatched edge choice for an idle-low slave; model decides
    sck = 0; idle(4);
    ss_active = 1; idle(2);
    send_lo_first(8'h96, 5, 0);
    idle(6); ss_active = 0; idle(2);
    rise_sel = 1;

    // R7: partial byte then deselect
    ss_active = 1; idle(2);
    for (int i = 0; i < 3; i++) begin miso = 1; idle(2); sck = 1; idle(2); sck = 0; end
    idle(6); ss_active = 0; idle(3); ss_active = 1; idle(2);
    send_lo_first(8'h5A, 2, 0);
    idle(6);
    chk("R7 byte 5A", 32'(rx_byte), 32'h5A);

    // R12: read lands on the completion cycle while full is set
    send_lo_first(8'hE1, 2, 1);
    idle(6);
    chk("R12 full after read+load", 32'(rx_full), 1);
    chk("R12 byte E1", 32'(rx_byte), 32'hE1);

    // R8: partial byte then contention error
    for (int i = 0; i < 5; i++) begin miso = 0; idle(2); sck = 1; idle(2); sck = 0; end
    idle(6); bus_err = 1; idle(1); bus_err = 0; idle(2);
    send_lo_first(8'h81, 3, 0);
    idle(6);
    chk("R8 byte 81", 32'(rx_byte), 32'h81);

    // R9: disable clears flag, keeps data, drops partial word
    en = 0; idle(2);
    chk("R9 full cleared", 32'(rx_full), 0);
    chk("R9 byte kept", 32'(rx_byte), 32'h81);
    en = 1; idle(2);
    for (int i = 0; i < 3; i++) begin miso = 1; idle(2); sck = 1; idle(2); sck = 0; end
    idle(6); en = 0; idle(1); en = 1; idle(2);
    send_lo_first(8'h7E, 2, 0);
    idle(6); ss_active = 0; idle(2);
    chk("R9 byte 7E", 32'(rx_byte), 32'h7E);
    chk("R9 full set", 32'(rx_full), 1);

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule